// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block sits in front of a synchronous memory array. It captures a start word address when an address strobe qualifies, then produces the internal word address for a burst of four beats. The upper address bits stay fixed for the whole burst. Only the two least significant bits are sequenced, by a 2-bit beat counter that moves forward on each clock edge where the advance input is asserted.

A load can come from either of two active-low strobes. The controller-side strobe loads unconditionally. The processor-side strobe loads only while chip enable is asserted. A static order select chooses one of two sequences. Interleaved order XORs the start bits with the beat count. Linear order adds the beat count to the start bits and wraps within the aligned group of four.

Top module: `burst_addr_gen`

## Requirements
- R1: On a rising edge with `ctl_strobe_n` low, the start address is captured regardless of `ce_n`. After that edge, `word_addr` equals the captured address and `beat` is 0.
- R2: On a rising edge with `cpu_strobe_n` low and `ce_n` low, the start address is captured and `beat` becomes 0.
- R3: While `ce_n` is high, `cpu_strobe_n` has no effect: `word_addr` and `beat` are unchanged unless `ctl_strobe_n` or `adv_n` is low.
- R4: With no load, a rising edge with `adv_n` low increments `beat` by one. A rising edge with `adv_n` high leaves `beat` and `word_addr` unchanged.
- R5: With `order_sel` high (interleaved), `word_addr[1:0]` equals the start bits XOR `beat`.
- R6: With `order_sel` low (linear), `word_addr[1:0]` equals the start bits plus `beat`, modulo 4.
- R7: Between loads, `word_addr[ADDR_W-1:2]` never changes and equals the captured upper bits.
- R8: An advance from beat 3 wraps `beat` to 0, so `word_addr` returns to the start address.
- R9: A qualifying load takes priority over an advance on the same edge, even in the middle of a burst, and clears `beat` to 0.
- R10: While `rst_n` is low, `word_addr` and `beat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | Start word address |
| cpu_strobe_n | input | 1 | Processor-side load strobe, active low, gated by `ce_n` |
| ctl_strobe_n | input | 1 | Controller-side load strobe, active low, ungated |
| adv_n | input | 1 | Advance the beat counter, active low |
| ce_n | input | 1 | Chip enable, active low |
| order_sel | input | 1 | 1 selects interleaved order, 0 selects linear order; static |
| word_addr | output | ADDR_W | Internal word address of the current beat |
| beat | output | 2 | Beat index within the burst |

## Verification
The bench builds the block with `ADDR_W` = 12, and the checker is bound at that width as well. This narrow width lets the directed start addresses set the top address bit as well as every alignment of the two low bits. As a result, the fixed-upper-bits rule and both wrap sequences are exercised from all four starting offsets. The same scenarios are run once in interleaved order and once in linear order, with the order select changed only while the block is idle.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] word_addr,
  output logic [1:0]        beat
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      base_lo;
  logic [1:0]      cnt;
  logic            load;
  logic [1:0]      lo_seq;

  assign load = ~ctl_strobe_n | (~cpu_strobe_n & ~ce_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi <= '0;
      base_lo <= '0;
      cnt     <= '0;
    end else if (load) begin
      base_hi <= addr_in[ADDR_W-1:2];
      base_lo <= addr_in[1:0];
      cnt     <= '0;
    end else if (!adv_n) begin
      cnt <= cnt + 2'd1;
    end
  end

  assign lo_seq    = order_sel ? (base_lo ^ cnt) : (base_lo + cnt);
  assign word_addr = {base_hi, lo_seq};
  assign beat      = cnt;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              cpu_strobe_n,
  input logic              ctl_strobe_n,
  input logic              adv_n,
  input logic              ce_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] word_addr,
  input logic [1:0]        beat
);
  logic no_load;
  assign no_load = ctl_strobe_n & (cpu_strobe_n | ce_n);

  p_ctl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_strobe_n |=> (word_addr == $past(addr_in)) && (beat == 2'd0));

  p_cpu_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && !ce_n) |=> (word_addr == $past(addr_in)) && (beat == 2'd0));

  p_cpu_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && ctl_strobe_n && adv_n) |=> $stable(word_addr) && $stable(beat));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && !adv_n) |=> beat == $past(beat) + 2'd1);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && adv_n) |=> $stable(word_addr) && $stable(beat));

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    no_load |=> word_addr[ADDR_W-1:2] == $past(word_addr[ADDR_W-1:2]));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && !adv_n && beat == 2'd3) |=> beat == 2'd0);

  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (word_addr == '0 && beat == 2'd0)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          cpu_strobe_n, ctl_strobe_n, adv_n, ce_n, order_sel;
  logic [AW-1:0] word_addr;
  logic [1:0]    beat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .adv_n(adv_n), .ce_n(ce_n), .order_sel(order_sel),
    .word_addr(word_addr), .beat(beat)
  );

  function automatic logic [AW-1:0] ref_addr(logic [AW-1:0] s, logic [1:0] k, logic il);
    logic [1:0] lo;
    lo = il ? (s[1:0] ^ k) : (s[1:0] + k);
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] act_a, logic [AW-1:0] exp_a,
                       logic [1:0] act_b, logic [1:0] exp_b);
    checks++;
    if (act_a !== exp_a || act_b !== exp_b) begin
      errors++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, act_a, act_b, exp_a, exp_b);
    end
  endtask

  task automatic idle();
    cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1; ce_n = 1;
  endtask

  task automatic load(logic [AW-1:0] a, bit via_ctl);
    @(negedge clk);
    addr_in = a; adv_n = 1;
    if (via_ctl) begin ctl_strobe_n = 0; ce_n = 1; end
    else begin cpu_strobe_n = 0; ce_n = 0; end
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    idle(); order_sel = 1; addr_in = '1; rst_n = 0;
    repeat (3) @(negedge clk);
    check("R10 reset", word_addr, '0, beat, 2'd0);
    rst_n = 1;
  endtask

  task automatic t_burst(logic [AW-1:0] s, bit via_ctl);
    string tag;
    tag = order_sel ? "R5 interleaved" : "R6 linear";
    load(s, via_ctl);
    check(via_ctl ? "R1 ctl load" : "R2 cpu load", word_addr, ref_addr(s, 0, order_sel), beat, 2'd0);
    for (int k = 1; k <= 4; k++) begin
      adv_n = 0;
      @(negedge clk);
      adv_n = 1;
      if (k == 4) check("R8 wrap", word_addr, s, beat, 2'd0);
      else check(tag, word_addr, ref_addr(s, 2'(k), order_sel), beat, 2'(k));
    end
    check("R7 upper bits", {word_addr[AW-1:2], 2'b00}, {s[AW-1:2], 2'b00}, beat, 2'd0);
  endtask

  task automatic t_hold(logic [AW-1:0] s);
    load(s, 1);
    adv_n = 0; @(negedge clk); adv_n = 1;
    repeat (3) @(negedge clk);
    check("R4 hold", word_addr, ref_addr(s, 1, order_sel), beat, 2'd1);
  endtask

  task automatic t_ce_gate(logic [AW-1:0] s, logic [AW-1:0] other);
    load(s, 1);
    addr_in = other; ce_n = 1; cpu_strobe_n = 0;
    @(negedge clk);
    idle();
    check("R3 cpu strobe gated", word_addr, s, beat, 2'd0);
    addr_in = other; ctl_strobe_n = 0; ce_n = 1;
    @(negedge clk);
    idle();
    check("R1 ctl with ce high", word_addr, other, beat, 2'd0);
  endtask

  task automatic t_override(logic [AW-1:0] s, logic [AW-1:0] nxt);
    load(s, 0);
    adv_n = 0; @(negedge clk);
    adv_n = 0; @(negedge clk);
    addr_in = nxt; ctl_strobe_n = 0; adv_n = 0;
    @(negedge clk);
    idle();
    check("R9 load overrides advance", word_addr, ref_addr(nxt, 0, order_sel), beat, 2'd0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    for (int o = 1; o >= 0; o--) begin
      @(negedge clk);
      order_sel = o[0];
      t_burst(12'hA40, 1);
      t_burst(12'h8C1, 0);
      t_burst(12'h3E2, 1);
      t_burst(12'hF5B, 0);
      t_hold(12'h7A2);
      t_override(12'h123, 12'h9F7);
    end
    t_ce_gate(12'h456, 12'hBCD);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule